// File: doc/BRIEF.md
# Dual-Source Keyboard Controller Host Front End

This block is the host-facing half of a PC-style keyboard controller that serves a keyboard and an auxiliary pointing device. A processor reaches it through a byte-wide bus with two registers: a data register and a combined command/status register. Each device side is stood in for by a byte-valid strobe with a data byte. The block keeps a one-bit pending flag per source and one holding byte per source. Both sources share a single logical output buffer, and keyboard bytes always win over auxiliary bytes.

A mode byte controls the two interrupt lines and the scan-code translation output. Software reads and writes the mode through two controller commands. Register offsets are the word index shifted left by a stride parameter, so the block can sit on buses with wider register spacing.

Top module: `kbc_host_front`

## Requirements
- R1: After reset no source is pending, the status byte reads 0x00, both interrupt lines are low, and the mode holds RESET_MODE (default 0x43), so the translation output is high.
- R2: Status bit 0 is set whenever any source is pending. Status bit 5 is set only when the auxiliary source is the only one pending. All other status bits read 0.
- R3: A data-register read returns the auxiliary byte only when the auxiliary source alone is pending, and the keyboard byte otherwise. A read with the bus read strobe clears the pending flag of the source it returned.
- R4: The keyboard interrupt is high exactly when keyboard data is pending, mode bit 0 is 1 and mode bit 4 is 0. It is a register that reflects the state produced by the same clock edge.
- R5: The auxiliary interrupt is high exactly when the auxiliary source alone is pending and mode bit 1 is 1. It is registered in the same way as the keyboard interrupt.
- R6: Writing command 0x20 to the command register loads the current mode byte into the auxiliary holding byte and marks the auxiliary source pending.
- R7: Writing command 0x60 arms a mode load. The next data-register write stores its byte as the mode, and the interrupts are recomputed at that edge. The translation output always equals mode bit 6.
- R8: The register offset is the bus address shifted right by STRIDE_SHIFT. Offset 0 is the data register and offset 1 is the command/status register. A read at any other offset returns 0xFF, and a write there changes nothing.
- R9: Any other command byte, including a command written while a load is armed, cancels the armed load. A data write with no armed load is ignored.
- R10: When a source's strobe arrives in the same cycle as a read that clears that source, the source stays pending and holds the new byte. A strobe also wins over a same-cycle command 0x20 for the auxiliary byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data for the addressed register, combinational |
| kbd_valid | input | 1 | Keyboard byte strobe |
| kbd_byte | input | BYTE_W | Keyboard byte |
| aux_valid | input | 1 | Auxiliary device byte strobe |
| aux_byte | input | BYTE_W | Auxiliary device byte |
| irq_kbd | output | 1 | Keyboard interrupt, registered |
| irq_aux | output | 1 | Auxiliary interrupt, registered |
| xlat_en | output | 1 | Scan-code translation enable (mode bit 6) |

## Verification
Read data is combinational, so the bench checks bus_rdata one time unit after it drives the address, before the clock edge that consumes the access. Pending flags, mode, status and both interrupt lines all change at the edge that accepts a strobe or a write. The bench therefore updates its model at that posedge and compares the interrupt lines and translation output at the following negedge. A status or data value that depends on an earlier access is checked by a later access, never in the cycle of the access that changed it.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
   localparam int NUM_SRC = 2;
   localparam int SRC_KBD = 0;
   localparam int SRC_AUX = 1;

   localparam int ST_OBF     = 0;
   localparam int ST_AUX_OBF = 5;

   localparam int MD_KBD_IE  = 0;
   localparam int MD_AUX_IE  = 1;
   localparam int MD_KBD_OFF = 4;
   localparam int MD_XLAT    = 6;

   localparam logic [7:0] CMD_GET_MODE = 8'h20;
   localparam logic [7:0] CMD_SET_MODE = 8'h60;

   typedef logic [NUM_SRC-1:0] src_mask_t;

   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_CTRL = 2'd1,
      REG_NONE = 2'd2
   } reg_sel_e;

   function automatic logic aux_alone(input src_mask_t m);
      return m == src_mask_t'(1 << SRC_AUX);
   endfunction
endpackage

// File: rtl/kbc_bus_decode.sv
module kbc_bus_decode
   import kbc_pkg::*;
#(
   parameter int ADDR_W       = 4,
   parameter int STRIDE_SHIFT = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output reg_sel_e          sel,
   output logic              data_rd,
   output logic              data_wr,
   output logic              ctrl_wr
);
   localparam int OFS_W = ADDR_W - STRIDE_SHIFT;

   logic [OFS_W-1:0] ofs;
   assign ofs = addr[ADDR_W-1:STRIDE_SHIFT];

   if (OFS_W == 1) begin : g_two_slot
      // every offset lands on a real register
      assign sel = ofs[0] ? REG_CTRL : REG_DATA;
   end else begin : g_sparse
      always_comb begin
         if (ofs == OFS_W'(0))      sel = REG_DATA;
         else if (ofs == OFS_W'(1)) sel = REG_CTRL;
         else                       sel = REG_NONE;
      end
   end

   assign data_rd = rd && (sel == REG_DATA);
   assign data_wr = wr && (sel == REG_DATA);
   assign ctrl_wr = wr && (sel == REG_CTRL);
endmodule

// File: rtl/kbc_src_arbiter.sv
module kbc_src_arbiter
   import kbc_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             src_valid,
   input  logic [NUM_SRC-1:0][BYTE_W-1:0] src_byte,
   input  logic                           inj_aux,
   input  logic [BYTE_W-1:0]              inj_byte,
   input  logic                           pop,
   output src_mask_t                      pend_q,
   output src_mask_t                      pend_nxt,
   output logic [BYTE_W-1:0]              head_byte
);
   logic [NUM_SRC-1:0][BYTE_W-1:0] hold_vec;
   logic                           head_is_aux;

   // keyboard wins unless the auxiliary source is alone
   assign head_is_aux = aux_alone(pend_q);
   assign head_byte   = hold_vec[head_is_aux ? SRC_AUX : SRC_KBD];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam bit IS_AUX = (s == SRC_AUX);
      logic              pend_r;
      logic              pend_d;
      logic [BYTE_W-1:0] hold_r;
      logic [BYTE_W-1:0] hold_d;
      logic              popped;
      logic              inject;

      assign popped = pop && (head_is_aux == IS_AUX);
      assign inject = IS_AUX ? inj_aux : 1'b0;

      always_comb begin
         pend_d = pend_r;
         hold_d = hold_r;
         if (popped) pend_d = 1'b0;
         if (inject) begin
            pend_d = 1'b1;
            hold_d = inj_byte;
         end
         if (src_valid[s]) begin
            pend_d = 1'b1;
            hold_d = src_byte[s];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_r <= 1'b0;
            hold_r <= '0;
         end else begin
            pend_r <= pend_d;
            hold_r <= hold_d;
         end
      end

      assign pend_q[s]   = pend_r;
      assign pend_nxt[s] = pend_d;
      assign hold_vec[s] = hold_r;
   end
endmodule

// File: rtl/kbc_cmd_ctrl.sv
module kbc_cmd_ctrl
   import kbc_pkg::*;
#(
   parameter int                BYTE_W     = 8,
   parameter logic [BYTE_W-1:0] RESET_MODE = 8'h43
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              data_wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] mode_q,
   output logic [BYTE_W-1:0] mode_nxt,
   output logic              armed_q,
   output logic              inj_aux,
   output logic [BYTE_W-1:0] inj_byte,
   output logic              xlat_en
);
   localparam logic [BYTE_W-1:0] GET_CODE = BYTE_W'(CMD_GET_MODE);
   localparam logic [BYTE_W-1:0] SET_CODE = BYTE_W'(CMD_SET_MODE);

   logic armed_d;

   always_comb begin
      armed_d  = armed_q;
      mode_nxt = mode_q;
      if (ctrl_wr) begin
         armed_d = (wdata == SET_CODE);
      end else if (data_wr) begin
         armed_d = 1'b0;
         if (armed_q) mode_nxt = wdata;
      end
   end

   assign inj_aux  = ctrl_wr && (wdata == GET_CODE);
   assign inj_byte = mode_q;
   assign xlat_en  = mode_q[MD_XLAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= RESET_MODE;
         armed_q <= 1'b0;
      end else begin
         mode_q  <= mode_nxt;
         armed_q <= armed_d;
      end
   end
endmodule

// File: rtl/kbc_irq_gen.sv
module kbc_irq_gen
   import kbc_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  src_mask_t         pend_q,
   input  src_mask_t         pend_nxt,
   input  logic [BYTE_W-1:0] mode_nxt,
   output logic              irq_kbd,
   output logic              irq_aux,
   output logic [BYTE_W-1:0] status_byte
);
   logic kbd_lvl;
   logic aux_lvl;

   assign kbd_lvl = pend_nxt[SRC_KBD] && mode_nxt[MD_KBD_IE] && !mode_nxt[MD_KBD_OFF];
   assign aux_lvl = aux_alone(pend_nxt) && mode_nxt[MD_AUX_IE];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_kbd <= 1'b0;
         irq_aux <= 1'b0;
      end else begin
         irq_kbd <= kbd_lvl;
         irq_aux <= aux_lvl;
      end
   end

   always_comb begin
      status_byte             = '0;
      status_byte[ST_OBF]     = |pend_q;
      status_byte[ST_AUX_OBF] = aux_alone(pend_q);
   end
endmodule

// File: rtl/kbc_host_front.sv
module kbc_host_front
   import kbc_pkg::*;
#(
   parameter int                ADDR_W       = 4,
   parameter int                STRIDE_SHIFT = 2,
   parameter int                BYTE_W       = 8,
   parameter logic [BYTE_W-1:0] RESET_MODE   = 8'h43
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              kbd_valid,
   input  logic [BYTE_W-1:0] kbd_byte,
   input  logic              aux_valid,
   input  logic [BYTE_W-1:0] aux_byte,
   output logic              irq_kbd,
   output logic              irq_aux,
   output logic              xlat_en
);
   if (STRIDE_SHIFT < 0 || STRIDE_SHIFT >= ADDR_W) begin : g_bad_stride
      $error("kbc_host_front: STRIDE_SHIFT must lie in [0, ADDR_W-1]");
   end
   if (BYTE_W < 8) begin : g_bad_width
      $error("kbc_host_front: BYTE_W must be at least 8");
   end

   reg_sel_e                       sel;
   logic                           data_rd;
   logic                           data_wr;
   logic                           ctrl_wr;
   src_mask_t                      pend_q;
   src_mask_t                      pend_nxt;
   logic [BYTE_W-1:0]              head_byte;
   logic [BYTE_W-1:0]              mode_q;
   logic [BYTE_W-1:0]              mode_nxt;
   logic                           armed_q;
   logic                           inj_aux;
   logic [BYTE_W-1:0]              inj_byte;
   logic [BYTE_W-1:0]              status_byte;
   logic [NUM_SRC-1:0]             src_valid;
   logic [NUM_SRC-1:0][BYTE_W-1:0] src_byte;

   always_comb begin
      src_valid          = '0;
      src_byte           = '0;
      src_valid[SRC_KBD] = kbd_valid;
      src_valid[SRC_AUX] = aux_valid;
      src_byte[SRC_KBD]  = kbd_byte;
      src_byte[SRC_AUX]  = aux_byte;
   end

   kbc_bus_decode #(
      .ADDR_W      (ADDR_W),
      .STRIDE_SHIFT(STRIDE_SHIFT)
   ) u_dec (
      .addr   (bus_addr),
      .rd     (bus_rd),
      .wr     (bus_wr),
      .sel    (sel),
      .data_rd(data_rd),
      .data_wr(data_wr),
      .ctrl_wr(ctrl_wr)
   );

   kbc_cmd_ctrl #(
      .BYTE_W    (BYTE_W),
      .RESET_MODE(RESET_MODE)
   ) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (ctrl_wr),
      .data_wr (data_wr),
      .wdata   (bus_wdata),
      .mode_q  (mode_q),
      .mode_nxt(mode_nxt),
      .armed_q (armed_q),
      .inj_aux (inj_aux),
      .inj_byte(inj_byte),
      .xlat_en (xlat_en)
   );

   kbc_src_arbiter #(
      .BYTE_W(BYTE_W)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_valid(src_valid),
      .src_byte (src_byte),
      .inj_aux  (inj_aux),
      .inj_byte (inj_byte),
      .pop      (data_rd),
      .pend_q   (pend_q),
      .pend_nxt (pend_nxt),
      .head_byte(head_byte)
   );

   kbc_irq_gen #(
      .BYTE_W(BYTE_W)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_q     (pend_q),
      .pend_nxt   (pend_nxt),
      .mode_nxt   (mode_nxt),
      .irq_kbd    (irq_kbd),
      .irq_aux    (irq_aux),
      .status_byte(status_byte)
   );

   always_comb begin
      unique case (sel)
         REG_DATA: bus_rdata = head_byte;
         REG_CTRL: bus_rdata = status_byte;
         default:  bus_rdata = '1;
      endcase
   end
endmodule

// File: rtl/kbc_host_front_chk.sv
module kbc_host_front_chk
   import kbc_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_kbd,
   input logic              irq_aux,
   input src_mask_t         pend_q,
   input logic [BYTE_W-1:0] mode_q,
   input logic              armed_q,
   input logic              data_wr,
   input logic              data_rd,
   input logic              kbd_valid,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic [BYTE_W-1:0] status_byte,
   input reg_sel_e          sel,
   input logic [BYTE_W-1:0] bus_rdata
);
   assert_irq_kbd_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_kbd |-> (pend_q[SRC_KBD] && mode_q[MD_KBD_IE] && !mode_q[MD_KBD_OFF]));

   assert_irq_aux_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_aux |-> (pend_q == src_mask_t'(1 << SRC_AUX) && mode_q[MD_AUX_IE]));

   assert_irq_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_kbd && irq_aux));

   assert_aux_obf_implies_obf_R2: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[ST_AUX_OBF] |-> status_byte[ST_OBF]);

   assert_mode_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && armed_q) |=> (mode_q == $past(bus_wdata)));

   assert_pop_clears_kbd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && pend_q[SRC_KBD] && !kbd_valid) |=> !pend_q[SRC_KBD]);

   assert_stray_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == REG_NONE) |-> (bus_rdata == {BYTE_W{1'b1}}));
endmodule

bind kbc_host_front kbc_host_front_chk #(.BYTE_W(BYTE_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_kbd    (irq_kbd),
   .irq_aux    (irq_aux),
   .pend_q     (pend_q),
   .mode_q     (mode_q),
   .armed_q    (armed_q),
   .data_wr    (data_wr),
   .data_rd    (data_rd),
   .kbd_valid  (kbd_valid),
   .bus_wdata  (bus_wdata),
   .status_byte(status_byte),
   .sel        (sel),
   .bus_rdata  (bus_rdata)
);

// File: tb/kbc_host_front_tb.sv
module kbc_host_front_tb_top;
   localparam int AW = 4;
   localparam int SH = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          kbd_valid = 1'b0;
   logic [7:0]    kbd_byte = '0;
   logic          aux_valid = 1'b0;
   logic [7:0]    aux_byte = '0;
   logic          irq_kbd;
   logic          irq_aux;
   logic          xlat_en;

   int n_chk = 0;
   int n_bad = 0;

   // reference model
   logic [1:0] m_pend = 2'b00;  // bit 0 keyboard, bit 1 auxiliary
   logic [7:0] m_kbd  = 8'h00;
   logic [7:0] m_aux  = 8'h00;
   logic [7:0] m_mode = 8'h43;
   logic       m_arm  = 1'b0;

   always #5 clk = ~clk;

   kbc_host_front #(
      .ADDR_W      (AW),
      .STRIDE_SHIFT(SH),
      .BYTE_W      (8),
      .RESET_MODE  (8'h43)
   ) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .kbd_valid(kbd_valid),
      .kbd_byte (kbd_byte),
      .aux_valid(aux_valid),
      .aux_byte (aux_byte),
      .irq_kbd  (irq_kbd),
      .irq_aux  (irq_aux),
      .xlat_en  (xlat_en)
   );

   function automatic logic [7:0] exp_rdata(input logic [AW-1:0] a);
      logic [AW-1:0] o;
      o = a >> SH;
      if (o == 0) return (m_pend == 2'b10) ? m_aux : m_kbd;
      if (o == 1) return {2'b00, m_pend == 2'b10, 4'b0000, |m_pend};
      return 8'hFF;
   endfunction

   function automatic string auto_tag(input logic [AW-1:0] a);
      logic [AW-1:0] o;
      o = a >> SH;
      if (o == 0) return "R3";
      if (o == 1) return "R2";
      return "R8";
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_outs();
      chk("R4", {7'b0, irq_kbd}, {7'b0, m_pend[0] & m_mode[0] & ~m_mode[4]});
      chk("R5", {7'b0, irq_aux}, {7'b0, (m_pend == 2'b10) & m_mode[1]});
      chk("R7", {7'b0, xlat_en}, {7'b0, m_mode[6]});
   endtask

   // called at a negedge; returns at the next negedge
   task automatic step(input string tag, input logic rd, input logic wr,
                       input logic [AW-1:0] a, input logic [7:0] wd,
                       input logic kv, input logic [7:0] kb,
                       input logic av, input logic [7:0] ab);
      logic [AW-1:0] o;
      chk_outs();
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      kbd_valid = kv; kbd_byte = kb; aux_valid = av; aux_byte = ab;
      #1;
      chk((tag == "") ? auto_tag(a) : tag, bus_rdata, exp_rdata(a));
      @(posedge clk);
      o = a >> SH;
      if (rd && o == 0) begin
         if (m_pend == 2'b10) m_pend[1] = 1'b0;
         else m_pend[0] = 1'b0;
      end
      if (wr && o == 1) begin
         if (wd == 8'h20) begin
            m_pend[1] = 1'b1;
            m_aux = m_mode;
         end
         m_arm = (wd == 8'h60);
      end else if (wr && o == 0) begin
         if (m_arm) m_mode = wd;
         m_arm = 1'b0;
      end
      if (kv) begin m_pend[0] = 1'b1; m_kbd = kb; end
      if (av) begin m_pend[1] = 1'b1; m_aux = ab; end
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0; kbd_valid = 1'b0; aux_valid = 1'b0;
   endtask

   task automatic look(input string tag, input logic [AW-1:0] a);
      step(tag, 1'b0, 1'b0, a, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00);
   endtask
   task automatic pop(input string tag, input logic [AW-1:0] a);
      step(tag, 1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00);
   endtask
   task automatic wr_ctl(input logic [7:0] v);
      step("", 1'b0, 1'b1, 4'd4, v, 1'b0, 8'h00, 1'b0, 8'h00);
   endtask
   task automatic wr_dat(input logic [AW-1:0] a, input logic [7:0] v);
      step("", 1'b0, 1'b1, a, v, 1'b0, 8'h00, 1'b0, 8'h00);
   endtask
   task automatic dev(input logic kv, input logic [7:0] kb, input logic av, input logic [7:0] ab);
      step("", 1'b0, 1'b0, 4'd0, 8'h00, kv, kb, av, ab);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", {7'b0, irq_kbd}, 8'h00);
      chk("R1", {7'b0, irq_aux}, 8'h00);
      chk("R1", {7'b0, xlat_en}, 8'h01);
      look("R1", 4'd4);

      // R2/R3: priority of keyboard over auxiliary
      dev(1'b1, 8'h1C, 1'b0, 8'h00);
      look("R2", 4'd4);
      dev(1'b0, 8'h00, 1'b1, 8'h08);
      look("R2", 4'd5);
      pop("R3", 4'd0);
      look("R2", 4'd4);
      pop("R3", 4'd0);
      look("R2", 4'd4);

      // R6: mode byte returned through the auxiliary slot
      wr_ctl(8'h20);
      pop("R6", 4'd0);

      // R7: mode load, keyboard disable, translation off
      wr_ctl(8'h60);
      wr_dat(4'd0, 8'h10);
      dev(1'b1, 8'h2A, 1'b0, 8'h00);
      look("R7", 4'd4);
      wr_ctl(8'h60);
      wr_dat(4'd0, 8'h43);
      pop("R7", 4'd0);

      // R9: stray command cancels the load; unarmed data write ignored
      wr_ctl(8'h60);
      wr_ctl(8'hAA);
      wr_dat(4'd0, 8'h00);
      wr_dat(4'd1, 8'h00);
      wr_ctl(8'h20);
      pop("R9", 4'd0);

      // R8: stride decode and unmapped offsets
      look("R8", 4'd8);
      look("R8", 4'd15);
      wr_dat(4'd12, 8'h60);
      wr_dat(4'd0, 8'h00);
      wr_ctl(8'h20);
      pop("R8", 4'd3);
      dev(1'b1, 8'h77, 1'b0, 8'h00);
      pop("R8", 4'd2);

      // R10: new byte arriving during the read that clears it
      dev(1'b1, 8'h11, 1'b0, 8'h00);
      step("R10", 1'b1, 1'b0, 4'd0, 8'h00, 1'b1, 8'h55, 1'b0, 8'h00);
      look("R10", 4'd4);
      pop("R10", 4'd0);
      step("R10", 1'b0, 1'b1, 4'd4, 8'h20, 1'b0, 8'h00, 1'b1, 8'h99);
      pop("R10", 4'd0);

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         int            kind;
         logic          rd;
         logic          wr;
         logic [AW-1:0] a;
         logic [7:0]    wd;
         kind = int'($urandom % 8);
         rd = 1'b0; wr = 1'b0;
         a = AW'($urandom);
         wd = 8'($urandom);
         case (kind)
            0, 1: begin rd = 1'b1; a = AW'($urandom % 4); end
            2:    a = AW'(4 + $urandom % 4);
            3:    begin rd = 1'b1; end
            4:    begin
                     wr = 1'b1; a = AW'(4);
                     case ($urandom % 3)
                        0: wd = 8'h20;
                        1: wd = 8'h60;
                        default: ;
                     endcase
                  end
            5:    begin wr = 1'b1; a = AW'($urandom % 4); end
            6:    begin wr = 1'b1; end
            default: ;
         endcase
         step("", rd, wr, a, wd,
              ($urandom % 4) == 0, 8'($urandom),
              ($urandom % 4) == 0, 8'($urandom));
      end
      chk_outs();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule